// File: doc/BRIEF.md
# Trigger-Latched Pulse Output Port

This block drives an 8-bit output port whose bits change only at chosen instants. Software writes the next pattern into a data register whenever it likes. Each output bit copies its data bit into its own output latch only when the trigger assigned to that bit fires. The port can work as one 8-bit group, or it can be split into a low and a high group (4+4 or 6+2). The low group always follows the underflow pulse of the first timer. The high group follows either the second timer's underflow pulse or a chosen edge of an external trigger pin. This gives waveforms whose edges are tied to timer events and not to software write timing.

Between the latches and the pins there are three controls. Each group has a cut control that clears its latches and holds them at zero. The first three bits can each be gated by a selectable PWM pulse. A global polarity control inverts every enabled output. Three enable bits pick which slices of the port act as pulse outputs. A disabled bit drives 0 and its output-enable is low.

Top module: `rt_pulse_port`

## Requirements
- R1: After reset every output latch and the data register hold 0, so `pout` is 0x00 (with `pol_inv`=0 and every slice enabled).
- R2: In 8-bit mode (`grp_mode`=0, and also the reserved code 3), a single-cycle `tmr_a_uf` pulse with `tmr_a_run`=1 copies all 8 data bits into the latches at that clock edge. Writing the data register without a trigger leaves the outputs unchanged.
- R3: A timer underflow pulse is ignored while that timer's run bit is 0.
- R4: In 4+4 mode (`grp_mode`=1), bits 0–3 latch on the first timer and bits 4–7 latch on the high-group source. Each group leaves the other unchanged.
- R5: In 6+2 mode (`grp_mode`=2), bits 0–5 latch on the first timer and bits 6–7 latch on the high-group source.
- R6: With `trg_sel` = 1 (falling), 2 (rising) or 3 (both), the high-group source is the external pin. An edge on `ext_trg` is synchronized through two flops. It updates the latches at the third rising clock edge after the pin changes and not earlier.
- R7: While `trg_sel` is nonzero, `tmr_b_uf` has no effect. An edge of the kind not selected (for example a rising edge with `trg_sel`=1) latches nothing. With `trg_sel`=0 the high group follows `tmr_b_uf` gated by `tmr_b_run`.
- R8: A data write and a trigger in the same cycle latch the value held before the write. The new value is latched at the next trigger.
- R9: With `pol_inv`=1 each enabled output is the inverse of its gated latch value. With `pol_inv`=0 it equals that value.
- R10: `cut_lo` clears the latches of the low group (the whole port in 8-bit mode) and `cut_hi` clears those of the high group. While a cut is held, triggers to that group are ignored.
- R11: `out_en[0]` enables bits 0–3, `out_en[1]` bits 4–5 and `out_en[2]` bits 6–7. A disabled bit drives `pout`=0 and `pout_oe`=0 regardless of polarity.
- R12: When `pwm_en[k]` is 1 (k = 0..2), output bit k is its latch value ANDed with the PWM pulse chosen by `pwm_sel` (0–2 pick `pwm_in[0..2]`, 3 picks constant 0). The AND is applied before polarity inversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Data register write strobe |
| wr_data | input | 8 | Next output pattern |
| grp_mode | input | 2 | 0: 8-bit, 1: 4+4, 2: 6+2, 3: as 8-bit |
| out_en | input | 3 | Slice enables (bits 0–3, 4–5, 6–7) |
| trg_sel | input | 2 | High-group source: 0 timer, 1 fall, 2 rise, 3 both edges |
| tmr_a_uf | input | 1 | First timer underflow pulse |
| tmr_a_run | input | 1 | First timer count start bit |
| tmr_b_uf | input | 1 | Second timer underflow pulse |
| tmr_b_run | input | 1 | Second timer count start bit |
| ext_trg | input | 1 | External trigger pin (asynchronous) |
| pol_inv | input | 1 | Invert enabled outputs |
| cut_lo | input | 1 | Clear and hold low-group latches |
| cut_hi | input | 1 | Clear and hold high-group latches |
| pwm_en | input | 3 | PWM gating enable for bits 0–2 |
| pwm_sel | input | 2 | PWM pulse source select |
| pwm_in | input | 3 | PWM pulses from timers |
| pout | output | 8 | Port output |
| pout_oe | output | 8 | Per-bit output enable |

## Verification
A sequence of data patterns is pushed through each grouping mode. The low and high groups are fired separately, and the data changes between firings, so a bit routed to the wrong trigger shows up as a stale nibble or a stale pair. The external pin is toggled under each edge selection. The bench samples one cycle before and at the expected edge, which separates a correct two-flop latency from a shorter or longer one, and separates the selected edge from the unselected one. Writes placed on the same cycle as a trigger, cut pulses held across triggers, and PWM gating combined with inversion tell apart old-versus-new data, clear-versus-hold, and gate-then-invert versus invert-then-gate.

// File: rtl/rtp_pkg.sv
package rtp_pkg;

    typedef enum logic [1:0] {
        GRP_8   = 2'd0,
        GRP_44  = 2'd1,
        GRP_62  = 2'd2,
        GRP_RSV = 2'd3
    } grp_mode_e;

    typedef enum logic [1:0] {
        TSRC_TMR  = 2'd0,
        TSRC_FALL = 2'd1,
        TSRC_RISE = 2'd2,
        TSRC_BOTH = 2'd3
    } tsrc_e;

endpackage

// File: rtl/rtp_ext_edge.sv
module rtp_ext_edge
    import rtp_pkg::*;
#(
    parameter int SYNC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin,
    input  logic [1:0] edge_sel,
    output logic       trg_pulse
);

    typedef struct packed {
        logic [SYNC-1:0] sync;
        logic            prev;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic     rise, fall;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC-2:0], pin};
        st_d.prev = st_q.sync[SYNC-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rise = st_q.sync[SYNC-1] & ~st_q.prev;
        fall = ~st_q.sync[SYNC-1] & st_q.prev;
        unique case (tsrc_e'(edge_sel))
            TSRC_FALL: trg_pulse = fall;
            TSRC_RISE: trg_pulse = rise;
            TSRC_BOTH: trg_pulse = rise | fall;
            default:   trg_pulse = 1'b0;
        endcase
    end

    // R6: a detected edge lasts exactly one clock
    a_r6_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
    a_r6_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

endmodule

// File: rtl/rtp_trig_route.sv
module rtp_trig_route
    import rtp_pkg::*;
#(
    parameter int W       = 8,
    parameter int SPLIT44 = 4,
    parameter int SPLIT62 = 6
) (
    input  logic [1:0]   grp_mode,
    input  logic         trg_lo,
    input  logic         trg_hi,
    input  logic         cut_lo,
    input  logic         cut_hi,
    output logic [W-1:0] trig_vec,
    output logic [W-1:0] cut_vec
);

    logic is44, is62;

    always_comb begin
        is44 = (grp_mode_e'(grp_mode) == GRP_44);
        is62 = (grp_mode_e'(grp_mode) == GRP_62);
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic hi_grp;
        always_comb begin
            hi_grp      = (is44 && (i >= SPLIT44)) || (is62 && (i >= SPLIT62));
            trig_vec[i] = hi_grp ? trg_hi : trg_lo;
            cut_vec[i]  = hi_grp ? cut_hi : cut_lo;
        end
    end

endmodule

// File: rtl/rtp_out_stage.sv
module rtp_out_stage #(
    parameter int W       = 8,
    parameter int SPLIT44 = 4,
    parameter int SPLIT62 = 6,
    parameter int N_PWMB  = 3,
    parameter int N_PSRC  = 3,
    parameter int PSEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      lat,
    input  logic [2:0]        out_en,
    input  logic              pol,
    input  logic [N_PWMB-1:0] pwm_en,
    input  logic [PSEL_W-1:0] pwm_sel,
    input  logic [N_PSRC-1:0] pwm_in,
    output logic [W-1:0]      pout,
    output logic [W-1:0]      pout_oe
);

    logic sel_pulse;

    always_comb begin
        sel_pulse = 1'b0;
        for (int k = 0; k < N_PSRC; k++) begin
            if (int'(pwm_sel) == k) sel_pulse = pwm_in[k];
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic en_b, gate_b;
        always_comb begin
            if (i < SPLIT44)      en_b = out_en[0];
            else if (i < SPLIT62) en_b = out_en[1];
            else                  en_b = out_en[2];
        end
        if (i < N_PWMB) begin : g_pwm
            always_comb gate_b = pwm_en[i] ? sel_pulse : 1'b1;
        end else begin : g_nopwm
            always_comb gate_b = 1'b1;
        end
        always_comb begin
            pout_oe[i] = en_b;
            pout[i]    = en_b ? ((lat[i] & gate_b) ^ pol) : 1'b0;
        end
    end

    // R11: a bit that is not enabled never drives high
    a_r11_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (pout & ~pout_oe) == '0);
    // R12: gating applies before inversion
    a_r12_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_en[0] && !sel_pulse && out_en[0]) |-> (pout[0] == pol));

endmodule

// File: rtl/rt_pulse_port.sv
module rt_pulse_port
    import rtp_pkg::*;
#(
    parameter int W       = 8,
    parameter int SPLIT44 = 4,
    parameter int SPLIT62 = 6,
    parameter int SYNC    = 2,
    parameter int N_PWMB  = 3,
    parameter int N_PSRC  = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    input  logic [1:0]  grp_mode,
    input  logic [2:0]  out_en,
    input  logic [1:0]  trg_sel,
    input  logic        tmr_a_uf,
    input  logic        tmr_a_run,
    input  logic        tmr_b_uf,
    input  logic        tmr_b_run,
    input  logic        ext_trg,
    input  logic        pol_inv,
    input  logic        cut_lo,
    input  logic        cut_hi,
    input  logic [2:0]  pwm_en,
    input  logic [1:0]  pwm_sel,
    input  logic [2:0]  pwm_in,
    output logic [7:0]  pout,
    output logic [7:0]  pout_oe
);

    localparam int PSEL_W = 2;

    typedef struct packed {
        logic [W-1:0] data;
        logic [W-1:0] lat;
    } port_st_t;

    port_st_t     st_d, st_q;
    logic         ext_pulse, trg_lo, trg_hi;
    logic [W-1:0] trig_vec, cut_vec;

    rtp_ext_edge #(.SYNC(SYNC)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin       (ext_trg),
        .edge_sel  (trg_sel),
        .trg_pulse (ext_pulse)
    );

    always_comb begin
        trg_lo = tmr_a_uf & tmr_a_run;
        trg_hi = (tsrc_e'(trg_sel) == TSRC_TMR) ? (tmr_b_uf & tmr_b_run) : ext_pulse;
    end

    rtp_trig_route #(.W(W), .SPLIT44(SPLIT44), .SPLIT62(SPLIT62)) u_route (
        .grp_mode (grp_mode),
        .trg_lo   (trg_lo),
        .trg_hi   (trg_hi),
        .cut_lo   (cut_lo),
        .cut_hi   (cut_hi),
        .trig_vec (trig_vec),
        .cut_vec  (cut_vec)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.data = wr_data[W-1:0];
        for (int i = 0; i < W; i++) begin
            if (cut_vec[i])       st_d.lat[i] = 1'b0;
            else if (trig_vec[i]) st_d.lat[i] = st_q.data[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    rtp_out_stage #(
        .W(W), .SPLIT44(SPLIT44), .SPLIT62(SPLIT62),
        .N_PWMB(N_PWMB), .N_PSRC(N_PSRC), .PSEL_W(PSEL_W)
    ) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .lat     (st_q.lat),
        .out_en  (out_en),
        .pol     (pol_inv),
        .pwm_en  (pwm_en[N_PWMB-1:0]),
        .pwm_sel (pwm_sel),
        .pwm_in  (pwm_in[N_PSRC-1:0]),
        .pout    (pout),
        .pout_oe (pout_oe)
    );

    // R2 / R8: triggered bits take the data held before this edge
    a_r2_latch_old_data: assert property (@(posedge clk) disable iff (!rst_n)
        (|(trig_vec & ~cut_vec)) |=>
        (((st_q.lat ^ $past(st_q.data)) & $past(trig_vec & ~cut_vec)) == '0));
    // R3: without trigger or cut the latches hold
    a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_vec == '0 && cut_vec == '0) |=> $stable(st_q.lat));
    // R10: a cut clears its group
    a_r10_cut_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (|cut_vec) |=> ((st_q.lat & $past(cut_vec)) == '0));

endmodule

// File: tb/sim_rt_pulse_port.sv
module sim_rt_pulse_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] grp_mode = 2'd0;
    logic [2:0] out_en = 3'b111;
    logic [1:0] trg_sel = 2'd0;
    logic       tmr_a_uf = 1'b0, tmr_a_run = 1'b1;
    logic       tmr_b_uf = 1'b0, tmr_b_run = 1'b1;
    logic       ext_trg = 1'b0;
    logic       pol_inv = 1'b0;
    logic       cut_lo = 1'b0, cut_hi = 1'b0;
    logic [2:0] pwm_en = '0;
    logic [1:0] pwm_sel = '0;
    logic [2:0] pwm_in = '0;
    logic [7:0] pout, pout_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0] q_val[$];
    string       q_tag[$];
    event        chk_ev;

    always #5 clk = ~clk;

    rt_pulse_port u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .grp_mode(grp_mode), .out_en(out_en), .trg_sel(trg_sel),
        .tmr_a_uf(tmr_a_uf), .tmr_a_run(tmr_a_run),
        .tmr_b_uf(tmr_b_uf), .tmr_b_run(tmr_b_run),
        .ext_trg(ext_trg), .pol_inv(pol_inv),
        .cut_lo(cut_lo), .cut_hi(cut_hi),
        .pwm_en(pwm_en), .pwm_sel(pwm_sel), .pwm_in(pwm_in),
        .pout(pout), .pout_oe(pout_oe)
    );

    // monitor: pops expected items and compares with the ports
    initial begin
        forever begin
            @(chk_ev);
            while (q_val.size() > 0) begin
                logic [15:0] e;
                string       t;
                e = q_val.pop_front();
                t = q_tag.pop_front();
                checks++;
                if ({pout, pout_oe} !== e) begin
                    errors++;
                    $display("FAIL %s: pout=%h oe=%h expected pout=%h oe=%h",
                             t, pout, pout_oe, e[15:8], e[7:0]);
                end
            end
        end
    end

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input logic [7:0] p, input logic [7:0] oe, input string tag);
        #2;
        q_val.push_back({p, oe});
        q_tag.push_back(tag);
        ->chk_ev;
        #1;
    endtask

    task automatic write(input logic [7:0] d);
        wr_data = d; wr_en = 1'b1;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic pulse_a();
        tmr_a_uf = 1'b1;
        cyc();
        tmr_a_uf = 1'b0;
    endtask

    task automatic pulse_b();
        tmr_b_uf = 1'b1;
        cyc();
        tmr_b_uf = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #23 rst_n = 1'b1;
        cyc();
        expect_out(8'h00, 8'hFF, "R1 reset state");

        // R2: write alone does nothing, trigger copies all bits
        write(8'hA5);
        expect_out(8'h00, 8'hFF, "R2 no trigger no change");
        pulse_a();
        expect_out(8'hA5, 8'hFF, "R2 8-bit latch");

        // R3: stopped timer ignored
        tmr_a_run = 1'b0;
        write(8'h3C);
        pulse_a();
        expect_out(8'hA5, 8'hFF, "R3 stopped timer ignored");
        tmr_a_run = 1'b1;

        // R4: 4+4
        grp_mode = 2'd1;
        pulse_b();
        expect_out(8'h35, 8'hFF, "R4 high nibble on B");
        pulse_a();
        expect_out(8'h3C, 8'hFF, "R4 low nibble on A");

        // R5: 6+2
        grp_mode = 2'd2;
        write(8'hC3);
        pulse_a();
        expect_out(8'h03, 8'hFF, "R5 bits0-5 on A");
        pulse_b();
        expect_out(8'hC3, 8'hFF, "R5 bits6-7 on B");

        // R8: write and trigger together
        wr_data = 8'h5A; wr_en = 1'b1; tmr_a_uf = 1'b1;
        cyc();
        wr_en = 1'b0; tmr_a_uf = 1'b0;
        expect_out(8'hC3, 8'hFF, "R8 same-cycle keeps old data");
        pulse_a();
        expect_out(8'hDA, 8'hFF, "R8 new data at next trigger");

        // R9: polarity
        pol_inv = 1'b1;
        expect_out(8'h25, 8'hFF, "R9 inverted");
        pol_inv = 1'b0;

        // R10: cuts in 4+4
        grp_mode = 2'd1;
        cut_lo = 1'b1;
        cyc();
        cut_lo = 1'b0;
        expect_out(8'hD0, 8'hFF, "R10 cut low group");
        cut_hi = 1'b1;
        cyc();
        cut_hi = 1'b0;
        expect_out(8'h00, 8'hFF, "R10 cut high group");
        write(8'hFF);
        cut_lo = 1'b1;
        pulse_a();
        expect_out(8'h00, 8'hFF, "R10 trigger ignored under cut");
        cut_lo = 1'b0;
        pulse_a();
        expect_out(8'h0F, 8'hFF, "R10 released cut latches");
        pulse_b();
        expect_out(8'hFF, 8'hFF, "R10 high group after cuts");

        // R11: slice enables
        out_en = 3'b001;
        expect_out(8'h0F, 8'h0F, "R11 only low slice");
        out_en = 3'b110;
        expect_out(8'hF0, 8'hF0, "R11 upper slices");
        out_en = 3'b001; pol_inv = 1'b1;
        expect_out(8'h00, 8'h0F, "R11 disabled stays low when inverted");
        out_en = 3'b111; pol_inv = 1'b0;

        // R12: PWM gating
        pwm_en = 3'b101; pwm_sel = 2'd1; pwm_in = 3'b000;
        expect_out(8'hFA, 8'hFF, "R12 gate low");
        pwm_in = 3'b010;
        expect_out(8'hFF, 8'hFF, "R12 gate high");
        pwm_in = 3'b000; pol_inv = 1'b1;
        expect_out(8'h05, 8'hFF, "R12 gate before inversion");
        pol_inv = 1'b0; pwm_sel = 2'd3; pwm_in = 3'b111;
        expect_out(8'hFA, 8'hFF, "R12 select 3 is constant low");
        pwm_en = 3'b000;

        // R6 / R7: external trigger, 4+4 mode
        trg_sel = 2'd2;
        write(8'h00);
        pulse_b();
        expect_out(8'hFF, 8'hFF, "R7 timer B ignored when pin selected");
        ext_trg = 1'b1;
        wait_cyc(2);
        expect_out(8'hFF, 8'hFF, "R6 no latch before sync delay");
        cyc();
        expect_out(8'h0F, 8'hFF, "R6 rising edge latches");

        trg_sel = 2'd1;
        write(8'hF0);
        ext_trg = 1'b0;
        wait_cyc(3);
        expect_out(8'hFF, 8'hFF, "R6 falling edge latches");
        write(8'h00);
        ext_trg = 1'b1;
        wait_cyc(5);
        expect_out(8'hFF, 8'hFF, "R7 rising ignored under falling select");

        trg_sel = 2'd3;
        ext_trg = 1'b0;
        wait_cyc(3);
        expect_out(8'h0F, 8'hFF, "R6 both edges: falling");
        write(8'hF0);
        ext_trg = 1'b1;
        wait_cyc(3);
        expect_out(8'hFF, 8'hFF, "R6 both edges: rising");

        // R7: timer source back, stopped timer B ignored
        trg_sel = 2'd0;
        write(8'h00);
        tmr_b_run = 1'b0;
        pulse_b();
        expect_out(8'hFF, 8'hFF, "R7 stopped timer B ignored");
        tmr_b_run = 1'b1;
        pulse_b();
        expect_out(8'h0F, 8'hFF, "R7 timer B source restored");

        // R2: reserved mode acts as 8-bit
        grp_mode = 2'd3;
        pulse_a();
        expect_out(8'h00, 8'hFF, "R2 reserved mode all bits on A");

        wait_cyc(2);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule